// File: doc/BRIEF.md
# Raster Timing Generator

This block turns a pixel clock into a display raster. A horizontal and a vertical counter step through a frame whose length, sync pulses, visible window and addressable area are set over a simple register write port. From the live counts it drives horizontal and vertical sync, an active-video flag for the addressable area, a border flag for the visible area outside it, and a pixel colour. The pixel colour is the incoming stream pixel, a programmable border colour or a programmable blank colour. Both counters start at zero on the leading edge of sync. Every window edge is therefore an absolute count: sync, then back porch, then left or top border, then addressable pixels, then right or bottom border, then front porch.

Incoming pixels arrive on a valid/ready stream. The block raises ready only for positions inside the addressable area while the counters run. A pixel transfers when valid and ready are both high, and it appears on the pixel output in the same cycle. A source that is not valid at that moment is not waited for: the position shows the blank colour, and the raster never stalls. The pixel output has no handshake, because a display cannot apply back-pressure. Timing writes go to shadow registers. A complete timing set is checked, and it is copied into the working set only at a frame boundary.

Register map for the write port (register number, then field bits): 0 control, with bit 0 run and bit 1 force-blank; 1 horizontal total minus one; 2 vertical total minus one; 3 horizontal sync end; 4 vertical sync end; 5 horizontal visible window, with [11:0] the first visible count and [27:16] the first blank count; 6 the same for vertical; 7 horizontal addressable window, with [11:0] the first addressable count and [27:16] the first count after it; 8 the same for vertical; 9 sync polarity, with bit 0 for horizontal and bit 1 for vertical; 10 blank colour; 11 border colour. A colour is red in [23:16], green in [15:8] and blue in [7:0]. The stream pixel uses the same packing.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal count runs from 0 up to the programmed total-minus-one and then returns to 0. The vertical count advances by one each time the horizontal count returns to 0, and it returns to 0 after reaching its own total-minus-one.
- R2: A sync pulse is asserted while its count is below the programmed sync end. With polarity bit 0 the pin is high while asserted; with polarity bit 1 the pin is low while asserted.
- R3: A count is in the visible window when it is at or above the first visible count and below the first blank count. stat_vblank is 1 whenever the vertical count is outside the vertical visible window, and no active or border flag is raised then.
- R4: vid_active is 1 when both counts are visible and inside the addressable window. vid_border is 1 when both counts are visible and at least one lies outside the addressable window. The two flags are never 1 together.
- R5: The pixel output carries the stream pixel when a transfer happens. It carries the border colour when vid_border is 1. It carries the blank colour in every other position, including an addressable position where no transfer happens.
- R6: While force-blank (register 0 bit 1) is set, the pixel output is the blank colour at every position. Sync, flags and the stream handshake are unchanged.
- R7: pix_in_ready is 1 only while run is set and vid_active is 1.
- R8: While run (register 0 bit 0) is clear, both counts hold their values, and pix_in_ready stays 0.
- R9: stat_frame is a 16-bit count that wraps and increments by one when the vertical count returns to 0.
- R10: A new timing set written to registers 1 to 9 takes effect at the start of the next frame. It is also loaded while the block is stopped with both counts at 0. A frame never mixes old and new values.
- R11: cfg_reject is 1, and the shadow timing set is never applied, in any of three cases: horizontal front porch (total minus first blank count) below 4, back porch (first visible count minus sync end) below 4, or horizontal blanking (front porch plus first visible count) below 56.
- R12: After reset both counts and stat_frame are 0, run and force-blank are clear, cfg_reject is 0, and the working timing is a valid built-in set (100 by 10 counts).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register number |
| cfg_wdata | input | 32 | Register write data |
| pix_in_valid | input | 1 | Stream pixel valid |
| pix_in_ready | output | 1 | Stream pixel ready |
| pix_in_data | input | 24 | Stream pixel, red/green/blue |
| hsync | output | 1 | Horizontal sync pin |
| vsync | output | 1 | Vertical sync pin |
| vid_active | output | 1 | Addressable area flag |
| vid_border | output | 1 | Border area flag |
| pix_out | output | 24 | Output pixel colour |
| stat_hcount | output | 12 | Live horizontal count |
| stat_vcount | output | 12 | Live vertical count |
| stat_vblank | output | 1 | Vertical blank flag |
| stat_frame | output | 16 | Frame counter |
| cfg_reject | output | 1 | Shadow timing is invalid |

## Verification
Every output is decoded from the two counts in the same cycle, so a wrong count shows at once on stat_hcount and stat_vcount. At the next window edge it also moves the sync and flag transitions away from their expected count. A wrong working timing set shows within one line as a window edge in the wrong place. A load on the wrong cycle shows in the first frame after the write as a line of the wrong length. A wrong colour selection shows on pix_out at the first position of the affected region.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  // register numbers on the write port
  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_HTOT   = 4'd1;
  localparam logic [3:0] A_VTOT   = 4'd2;
  localparam logic [3:0] A_HSYNC  = 4'd3;
  localparam logic [3:0] A_VSYNC  = 4'd4;
  localparam logic [3:0] A_HVIS   = 4'd5;
  localparam logic [3:0] A_VVIS   = 4'd6;
  localparam logic [3:0] A_HADDR  = 4'd7;
  localparam logic [3:0] A_VADDR  = 4'd8;
  localparam logic [3:0] A_POL    = 4'd9;
  localparam logic [3:0] A_BLANKC = 4'd10;
  localparam logic [3:0] A_BORDC  = 4'd11;

  localparam int HI_FIELD = 16;  // bit position of the second field in a window register

  // timing field indices
  localparam int F_HTOT = 0;
  localparam int F_VTOT = 1;
  localparam int F_HSE  = 2;
  localparam int F_VSE  = 3;
  localparam int F_HVB  = 4;   // first visible count, horizontal
  localparam int F_HVE  = 5;   // first blank count, horizontal
  localparam int F_VVB  = 6;
  localparam int F_VVE  = 7;
  localparam int F_HAB  = 8;   // first addressable count, horizontal
  localparam int F_HAE  = 9;   // first count after addressable, horizontal
  localparam int F_VAB  = 10;
  localparam int F_VAE  = 11;
  localparam int NF     = 12;

  function automatic int field_default(int f);
    case (f)
      F_HTOT: return 99;
      F_VTOT: return 9;
      F_HSE:  return 8;
      F_VSE:  return 2;
      F_HVB:  return 40;
      F_HVE:  return 64;
      F_VVB:  return 3;
      F_VVE:  return 8;
      F_HAB:  return 44;
      F_HAE:  return 60;
      F_VAB:  return 4;
      F_VAE:  return 7;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int COMP_W     = 8,
  parameter int MIN_HBLANK = 56,
  parameter int MIN_PORCH  = 4,
  localparam int PIX_W     = 3 * COMP_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [3:0]                  addr,
  input  logic [31:0]                 wdata,
  input  logic [CNT_W-1:0]            h_cnt,
  input  logic [CNT_W-1:0]            v_cnt,
  input  logic                        frame_end,
  output logic                        run,
  output logic                        force_blank,
  output logic [NF-1:0][CNT_W-1:0]    tim,
  output logic                        hpol_low,
  output logic                        vpol_low,
  output logic [PIX_W-1:0]            blank_rgb,
  output logic [PIX_W-1:0]            border_rgb,
  output logic                        reject
);
  localparam int WW = CNT_W + 2;

  logic [NF-1:0][CNT_W-1:0] sh;
  logic [1:0]               sh_pol;
  logic                     sh_ok, load;
  logic [WW-1:0]            len, fp, blank_len;
  logic                     unused_bits;

  assign unused_bits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run         <= 1'b0;
      force_blank <= 1'b0;
      blank_rgb   <= '0;
      border_rgb  <= '0;
      sh_pol      <= '0;
      for (int f = 0; f < NF; f++) sh[f] <= CNT_W'(field_default(f));
    end else if (we) begin
      case (addr)
        A_CTRL:   {force_blank, run} <= wdata[1:0];
        A_HTOT:   sh[F_HTOT] <= wdata[CNT_W-1:0];
        A_VTOT:   sh[F_VTOT] <= wdata[CNT_W-1:0];
        A_HSYNC:  sh[F_HSE]  <= wdata[CNT_W-1:0];
        A_VSYNC:  sh[F_VSE]  <= wdata[CNT_W-1:0];
        A_HVIS:   begin sh[F_HVB] <= wdata[CNT_W-1:0]; sh[F_HVE] <= wdata[HI_FIELD+CNT_W-1:HI_FIELD]; end
        A_VVIS:   begin sh[F_VVB] <= wdata[CNT_W-1:0]; sh[F_VVE] <= wdata[HI_FIELD+CNT_W-1:HI_FIELD]; end
        A_HADDR:  begin sh[F_HAB] <= wdata[CNT_W-1:0]; sh[F_HAE] <= wdata[HI_FIELD+CNT_W-1:HI_FIELD]; end
        A_VADDR:  begin sh[F_VAB] <= wdata[CNT_W-1:0]; sh[F_VAE] <= wdata[HI_FIELD+CNT_W-1:HI_FIELD]; end
        A_POL:    sh_pol <= wdata[1:0];
        A_BLANKC: blank_rgb  <= wdata[PIX_W-1:0];
        A_BORDC:  border_rgb <= wdata[PIX_W-1:0];
        default:  ;
      endcase
    end
  end

  // horizontal limits check on the shadow set
  always_comb begin
    len       = WW'(sh[F_HTOT]) + WW'(1);
    fp        = len - WW'(sh[F_HVE]);
    blank_len = fp + WW'(sh[F_HVB]);
    sh_ok     = (WW'(sh[F_HVE]) <= len)
             && (WW'(sh[F_HVB]) >= WW'(sh[F_HSE]) + WW'(MIN_PORCH))
             && (fp >= WW'(MIN_PORCH))
             && (blank_len >= WW'(MIN_HBLANK));
  end

  assign reject = !sh_ok;
  assign load   = sh_ok && (frame_end || (!run && h_cnt == '0 && v_cnt == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int f = 0; f < NF; f++) tim[f] <= CNT_W'(field_default(f));
      hpol_low <= 1'b0;
      vpol_low <= 1'b0;
    end else if (load) begin
      tim      <= sh;
      hpol_low <= sh_pol[0];
      vpol_low <= sh_pol[1];
    end
  end

  AST_APPLY_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    (tim != $past(tim)) |-> (h_cnt == '0 && v_cnt == '0)); // R10
endmodule

// File: rtl/rtg_counter.sv
module rtg_counter #(
  parameter int CNT_W   = 12,
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [CNT_W-1:0]   htot,
  input  logic [CNT_W-1:0]   vtot,
  output logic [CNT_W-1:0]   h_cnt,
  output logic [CNT_W-1:0]   v_cnt,
  output logic [FRAME_W-1:0] frame_cnt,
  output logic               frame_end
);
  logic line_end;

  assign line_end  = run && (h_cnt >= htot);
  assign frame_end = line_end && (v_cnt >= vtot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt     <= '0;
      v_cnt     <= '0;
      frame_cnt <= '0;
    end else begin
      if (line_end)  h_cnt <= '0;
      else if (run)  h_cnt <= h_cnt + 1'b1;
      if (frame_end) begin
        v_cnt     <= '0;
        frame_cnt <= frame_cnt + 1'b1;
      end else if (line_end) begin
        v_cnt <= v_cnt + 1'b1;
      end
    end
  end

  AST_H_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    h_cnt <= htot); // R1
  AST_V_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    v_cnt <= vtot); // R1
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(h_cnt) && $stable(v_cnt))); // R8
  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (frame_cnt == $past(frame_cnt) + 1'b1 && v_cnt == '0)); // R9
endmodule

// File: rtl/rtg_pixel.sv
module rtg_pixel
  import rtg_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int COMP_W = 8,
  localparam int PIX_W = 3 * COMP_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CNT_W-1:0]         h_cnt,
  input  logic [CNT_W-1:0]         v_cnt,
  input  logic [NF-1:0][CNT_W-1:0] tim,
  input  logic                     hpol_low,
  input  logic                     vpol_low,
  input  logic                     run,
  input  logic                     force_blank,
  input  logic [PIX_W-1:0]         blank_rgb,
  input  logic [PIX_W-1:0]         border_rgb,
  input  logic                     in_valid,
  input  logic [PIX_W-1:0]         in_data,
  output logic                     in_ready,
  output logic                     hsync,
  output logic                     vsync,
  output logic                     vid_active,
  output logic                     vid_border,
  output logic                     vblank,
  output logic [PIX_W-1:0]         pix_out
);
  logic h_vis, v_vis, h_addr, v_addr, take;

  assign hsync  = (h_cnt < tim[F_HSE]) ^ hpol_low;
  assign vsync  = (v_cnt < tim[F_VSE]) ^ vpol_low;
  assign h_vis  = (h_cnt >= tim[F_HVB]) && (h_cnt < tim[F_HVE]);
  assign v_vis  = (v_cnt >= tim[F_VVB]) && (v_cnt < tim[F_VVE]);
  assign h_addr = (h_cnt >= tim[F_HAB]) && (h_cnt < tim[F_HAE]);
  assign v_addr = (v_cnt >= tim[F_VAB]) && (v_cnt < tim[F_VAE]);

  assign vblank     = !v_vis;
  assign vid_active = h_vis && v_vis && h_addr && v_addr;
  assign vid_border = h_vis && v_vis && !(h_addr && v_addr);
  assign in_ready   = run && vid_active;
  assign take       = in_valid && in_ready;

  always_comb begin
    if (force_blank)     pix_out = blank_rgb;
    else if (take)       pix_out = in_data;
    else if (vid_border) pix_out = border_rgb;
    else                 pix_out = blank_rgb;
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vid_active, vid_border})); // R4
  AST_VBLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |-> (!vid_active && !vid_border)); // R3
  AST_READY_IN_AREA: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (vid_active && run)); // R7
  AST_FORCED_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    force_blank |-> (pix_out == blank_rgb)); // R6
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int COMP_W     = 8,
  parameter int FRAME_W    = 16,
  parameter int MIN_HBLANK = 56,
  parameter int MIN_PORCH  = 4,
  localparam int PIX_W     = 3 * COMP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [3:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  input  logic               pix_in_valid,
  output logic               pix_in_ready,
  input  logic [PIX_W-1:0]   pix_in_data,
  output logic               hsync,
  output logic               vsync,
  output logic               vid_active,
  output logic               vid_border,
  output logic [PIX_W-1:0]   pix_out,
  output logic [CNT_W-1:0]   stat_hcount,
  output logic [CNT_W-1:0]   stat_vcount,
  output logic               stat_vblank,
  output logic [FRAME_W-1:0] stat_frame,
  output logic               cfg_reject
);
  logic                     run, force_blank, hpol_low, vpol_low, frame_end;
  logic [NF-1:0][CNT_W-1:0] tim;
  logic [PIX_W-1:0]         blank_rgb, border_rgb;
  logic [CNT_W-1:0]         h_cnt, v_cnt;

  rtg_regs #(.CNT_W(CNT_W), .COMP_W(COMP_W), .MIN_HBLANK(MIN_HBLANK), .MIN_PORCH(MIN_PORCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .frame_end(frame_end),
    .run(run), .force_blank(force_blank), .tim(tim),
    .hpol_low(hpol_low), .vpol_low(vpol_low),
    .blank_rgb(blank_rgb), .border_rgb(border_rgb), .reject(cfg_reject)
  );

  rtg_counter #(.CNT_W(CNT_W), .FRAME_W(FRAME_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .htot(tim[F_HTOT]), .vtot(tim[F_VTOT]),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .frame_cnt(stat_frame), .frame_end(frame_end)
  );

  rtg_pixel #(.CNT_W(CNT_W), .COMP_W(COMP_W)) u_pix (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt), .tim(tim),
    .hpol_low(hpol_low), .vpol_low(vpol_low), .run(run), .force_blank(force_blank),
    .blank_rgb(blank_rgb), .border_rgb(border_rgb),
    .in_valid(pix_in_valid), .in_data(pix_in_data), .in_ready(pix_in_ready),
    .hsync(hsync), .vsync(vsync), .vid_active(vid_active), .vid_border(vid_border),
    .vblank(stat_vblank), .pix_out(pix_out)
  );

  assign stat_hcount = h_cnt;
  assign stat_vcount = v_cnt;
endmodule

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        pix_in_valid = 1'b0;
  logic        pix_in_ready;
  logic [23:0] pix_in_data = '0;
  logic        hsync, vsync, vid_active, vid_border, stat_vblank, cfg_reject;
  logic [23:0] pix_out;
  logic [11:0] stat_hcount, stat_vcount;
  logic [15:0] stat_frame;

  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam logic [23:0] C_BLANK = 24'h0A0B0C;
  localparam logic [23:0] C_BORD  = 24'h112233;
  localparam logic [23:0] C_PIX   = 24'h123456;

  // {h, v, hsync, vsync, active, border, vblank, colour kind (0 blank, 1 border, 2 stream)}
  localparam logic [30:0] TBL [12] = '{
    {12'd0,  12'd0, 5'b10001, 2'd0},
    {12'd7,  12'd1, 5'b10001, 2'd0},
    {12'd8,  12'd2, 5'b01001, 2'd0},
    {12'd40, 12'd3, 5'b01010, 2'd1},
    {12'd44, 12'd4, 5'b01100, 2'd2},
    {12'd39, 12'd5, 5'b01000, 2'd0},
    {12'd64, 12'd5, 5'b01000, 2'd0},
    {12'd59, 12'd6, 5'b01100, 2'd2},
    {12'd60, 12'd6, 5'b01010, 2'd1},
    {12'd63, 12'd7, 5'b01010, 2'd1},
    {12'd50, 12'd8, 5'b01001, 2'd0},
    {12'd99, 12'd9, 5'b01001, 2'd0}
  };

  raster_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pix_in_valid(pix_in_valid), .pix_in_ready(pix_in_ready), .pix_in_data(pix_in_data),
    .hsync(hsync), .vsync(vsync), .vid_active(vid_active), .vid_border(vid_border),
    .pix_out(pix_out), .stat_hcount(stat_hcount), .stat_vcount(stat_vcount),
    .stat_vblank(stat_vblank), .stat_frame(stat_frame), .cfg_reject(cfg_reject)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic go_to(input int h, input int v);
    int n = 0;
    while (!(stat_hcount == 12'(h) && stat_vcount == 12'(v)) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(n < 3000, "R1 position reached", {stat_vcount, stat_hcount}, {12'(v), 12'(h)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", total, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] exp_pix;
    logic [15:0] f0;
    logic [11:0] h0, v0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(stat_hcount == 0 && stat_vcount == 0, "R12 counts at reset", {stat_vcount, stat_hcount}, 0);
    check(stat_frame == 0, "R12 frame at reset", stat_frame, 0);
    check(cfg_reject == 0, "R12 reject at reset", cfg_reject, 0);
    check(pix_in_ready == 0, "R12 ready while stopped", pix_in_ready, 0);
    repeat (5) @(negedge clk);
    check(stat_hcount == 0, "R8 stopped after reset", stat_hcount, 0);

    // program the timing while stopped at origin
    wr(4'd1, 32'd99);  wr(4'd2, 32'd9);  wr(4'd3, 32'd8);  wr(4'd4, 32'd2);
    wr(4'd5, {16'd64, 16'd40}); wr(4'd6, {16'd8, 16'd3});
    wr(4'd7, {16'd60, 16'd44}); wr(4'd8, {16'd7, 16'd4});
    wr(4'd9, 32'd2); wr(4'd10, {8'd0, C_BLANK}); wr(4'd11, {8'd0, C_BORD});
    pix_in_valid = 1'b1; pix_in_data = C_PIX;
    wr(4'd0, 32'd1);

    for (int i = 0; i < 12; i++) begin
      go_to(int'(TBL[i][30:19]), int'(TBL[i][18:7]));
      check(hsync == TBL[i][6], "R2 hsync", hsync, TBL[i][6]);
      check(vsync == TBL[i][5], "R2 vsync polarity", vsync, TBL[i][5]);
      check(vid_active == TBL[i][4], "R4 active", vid_active, TBL[i][4]);
      check(vid_border == TBL[i][3], "R4 border", vid_border, TBL[i][3]);
      check(stat_vblank == TBL[i][2], "R3 vblank", stat_vblank, TBL[i][2]);
      check(pix_in_ready == TBL[i][4], "R7 ready", pix_in_ready, TBL[i][4]);
      exp_pix = (TBL[i][1:0] == 2'd2) ? C_PIX : (TBL[i][1:0] == 2'd1) ? C_BORD : C_BLANK;
      check(pix_out == exp_pix, "R5 colour", pix_out, exp_pix);
    end

    // R1 and R9: wrap from the last position of the frame
    f0 = stat_frame;
    @(negedge clk);
    check(stat_hcount == 0 && stat_vcount == 0, "R1 frame wrap", {stat_vcount, stat_hcount}, 0);
    check(stat_frame == f0 + 1'b1, "R9 frame count", stat_frame, f0 + 1'b1);
    go_to(99, 0);
    @(negedge clk);
    check(stat_hcount == 0 && stat_vcount == 1, "R1 line wrap", {stat_vcount, stat_hcount}, {12'd1, 12'd0});

    // R6 force blank
    wr(4'd0, 32'd3);
    go_to(50, 5);
    check(pix_out == C_BLANK, "R6 forced colour", pix_out, C_BLANK);
    check(pix_in_ready == 1 && vid_active == 1, "R6 handshake kept", {pix_in_ready, vid_active}, 3);
    wr(4'd0, 32'd1);

    // R5 no transfer in addressable area
    pix_in_valid = 1'b0;
    go_to(50, 5);
    check(pix_out == C_BLANK, "R5 no valid pixel", pix_out, C_BLANK);
    pix_in_valid = 1'b1;

    // R8 stop holds the counts
    wr(4'd0, 32'd0);
    h0 = stat_hcount; v0 = stat_vcount;
    repeat (20) @(negedge clk);
    check(stat_hcount == h0 && stat_vcount == v0, "R8 counts held", {stat_vcount, stat_hcount}, {v0, h0});
    check(pix_in_ready == 0, "R8 ready low stopped", pix_in_ready, 0);
    wr(4'd0, 32'd1);

    // R10 a new line length waits for the next frame
    go_to(10, 5);
    wr(4'd1, 32'd119);
    go_to(99, 5);
    @(negedge clk);
    check(stat_hcount == 0 && stat_vcount == 6, "R10 old length kept", {stat_vcount, stat_hcount}, {12'd6, 12'd0});
    go_to(99, 0);
    @(negedge clk);
    check(stat_hcount == 100, "R10 new length applied", stat_hcount, 100);
    wr(4'd1, 32'd99);
    go_to(0, 0);

    // R11 invalid sets are flagged and not applied
    wr(4'd5, {16'd97, 16'd40});
    check(cfg_reject == 1, "R11 short front porch", cfg_reject, 1);
    go_to(0, 0);
    go_to(70, 4);
    check(vid_border == 0 && pix_out == C_BLANK, "R11 rejected set unused", {vid_border, pix_out}, {1'b0, C_BLANK});
    wr(4'd5, {16'd90, 16'd40});
    check(cfg_reject == 1, "R11 short blanking", cfg_reject, 1);
    wr(4'd5, {16'd64, 16'd11});
    check(cfg_reject == 1, "R11 short back porch", cfg_reject, 1);
    wr(4'd5, {16'd64, 16'd40});
    check(cfg_reject == 0, "R11 valid again", cfg_reject, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule